// File: doc/BRIEF.md
# Multifunction Integer ALU

This block is a purely combinational integer ALU for a simple single-issue datapath. It takes two operands, a separate shift count and a small set of control fields, and returns one result word. The result comes from one of four units: a shifter, an adder/subtractor, a logic unit, or a signed compare that yields 0 or 1. Three status flags accompany the result. Sign and overflow always come from the adder. Zero reflects the selected result word.

The signed compare has no comparator of its own. It forces the adder to subtract and reads the true ordering from the sum's sign bit XOR the adder's overflow. The shifter has two variants, chosen by a parameter. One is a plain behavioural model. The other extends the operand to nearly twice its width and then runs a logarithmic right-shift ladder, so that left shifts and rotates use the same ladder. Both variants give identical results at the ports.

Top module: `mfalu`

## Requirements
- R1: `unit_sel` picks the unit that drives `result`: 2'b00 shifter, 2'b01 signed compare, 2'b10 adder/subtractor, 2'b11 logic unit.
- R2: With `unit_sel`=2'b10 and `sub_en`=0, `result` is `opa + opb` modulo 2^WIDTH.
- R3: With `unit_sel`=2'b10 and `sub_en`=1, `result` is `opa - opb` modulo 2^WIDTH, formed as opa + ~opb + 1.
- R4: `ovf_flag` is 1 exactly when the adder's two's-complement result does not fit in WIDTH signed bits. The adder subtracts when `sub_en`=1 or `unit_sel`=2'b01, and adds otherwise.
- R5: `sign_flag` equals the most significant bit of the adder's sum for the operation selected as in R4, whatever `unit_sel` is.
- R6: With `unit_sel`=2'b01, `result` is 1 when opa < opb as signed numbers and 0 otherwise. The bit sits in bit 0 and all upper bits are 0, even when the subtraction overflows.
- R7: With `unit_sel`=2'b11, `logic_op` selects the function: 2'b00 AND, 2'b01 OR, 2'b10 NOR, 2'b11 XOR.
- R8: With `unit_sel`=2'b00 and `shift_op`=2'b00, `result` is `opa` shifted left by `shamt`, with zeros entering at bit 0.
- R9: `shift_op`=2'b10 gives a logical right shift (zeros enter at the top). `shift_op`=2'b01 gives an arithmetic right shift (copies of opa's sign bit enter at the top).
- R10: `shift_op`=2'b11 rotates `opa` right by `shamt`. Bits leaving bit 0 re-enter at the top, and a count of 0 returns `opa` unchanged.
- R11: `zero_flag` is 1 exactly when the selected `result` word is all zeros.
- R12: The shift count comes only from `shamt`. Changing `opb` while the shifter is selected does not change `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH (32) | First operand; the data word for shifts |
| opb | input | WIDTH (32) | Second operand |
| shamt | input | log2(WIDTH) (5) | Shift or rotate count |
| unit_sel | input | 2 | Result unit select |
| sub_en | input | 1 | Adder mode: 0 add, 1 subtract |
| logic_op | input | 2 | Logic function select |
| shift_op | input | 2 | Shift kind select |
| result | output | WIDTH (32) | Selected result word |
| zero_flag | output | 1 | Result is all zeros |
| sign_flag | output | 1 | Adder sum sign bit |
| ovf_flag | output | 1 | Adder signed overflow |

## Verification
Some invariants hold on every evaluation, and the embedded assertions check them continuously:
- an add of opposite-signed operands never overflows;
- an overflowing sum has a sign opposite to opa;
- a rotate keeps opa's population count;
- a zero shift count is an identity;
- NOR output never shares a set bit with either operand;
- the compare result never has upper bits set.

Exact arithmetic values need the bench's reference model, which is compared every clock. So do the sign of each shift fill, the overflow boundaries at the most positive and most negative values, compares whose subtraction overflows, and independence from opb under shifts.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

   typedef enum logic [1:0] {
      SEL_SHIFT = 2'b00,
      SEL_SLT   = 2'b01,
      SEL_ARITH = 2'b10,
      SEL_LOGIC = 2'b11
   } unit_sel_e;

   typedef enum logic [1:0] {
      SH_LEFT  = 2'b00,
      SH_ARITH = 2'b01,
      SH_LOGIC = 2'b10,
      SH_ROT   = 2'b11
   } shift_op_e;

   typedef enum logic [1:0] {
      LG_AND = 2'b00,
      LG_OR  = 2'b01,
      LG_NOR = 2'b10,
      LG_XOR = 2'b11
   } logic_op_e;

endpackage

// File: rtl/alu_shifter.sv
`timescale 1ns/1ps
module alu_shifter
   import alu_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter int EXTEND_STYLE = 1,
   localparam int SHW         = $clog2(WIDTH),
   localparam int EXTW        = 2 * WIDTH - 1
) (
   input  logic [WIDTH-1:0] din,
   input  logic [SHW-1:0]   amt,
   input  shift_op_e        op,
   output logic [WIDTH-1:0] dout
);

   if (EXTEND_STYLE != 0 && EXTEND_STYLE != 1) begin : g_bad_style
      $error("alu_shifter: EXTEND_STYLE must be 0 or 1");
   end

   if (EXTEND_STYLE == 1) begin : g_ladder
      logic [EXTW-1:0] ext;
      logic [SHW-1:0]  eff;
      logic [EXTW-1:0] stg [SHW+1];

      always_comb begin
         eff = amt;
         unique case (op)
            SH_LEFT: begin
               ext = {din, {(WIDTH-1){1'b0}}};
               eff = ~amt;
            end
            SH_ARITH: ext = {{(WIDTH-1){din[WIDTH-1]}}, din};
            SH_LOGIC: ext = {{(WIDTH-1){1'b0}}, din};
            default:  ext = {din[WIDTH-2:0], din};
         endcase
      end

      assign stg[0] = ext;
      for (genvar i = 0; i < SHW; i++) begin : g_stage
         assign stg[i+1] = eff[i] ? (stg[i] >> (1 << i)) : stg[i];
      end
      assign dout = stg[SHW][WIDTH-1:0];
   end else begin : g_behav
      logic [2*WIDTH-1:0] rot;
      assign rot = {din, din} >> amt;
      always_comb begin
         unique case (op)
            SH_LEFT:  dout = din << amt;
            SH_ARITH: dout = $signed(din) >>> amt;
            SH_LOGIC: dout = din >> amt;
            default:  dout = rot[WIDTH-1:0];
         endcase
      end
   end

   always_comb begin
      if (op == SH_ROT)
         assert_rotate_keeps_bits_R10: assert ($countones(dout) == $countones(din))
            else $error("rotate changed population count");
      if (amt == '0)
         assert_zero_count_identity_R8: assert (dout == din)
            else $error("zero shift count altered data");
   end

endmodule

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
   parameter int WIDTH = 32,
   localparam int MSB  = WIDTH - 1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             ovf
);

   logic [WIDTH-1:0] b_eff;

   assign b_eff = b ^ {WIDTH{sub}};
   assign sum   = a + b_eff + WIDTH'(sub);
   assign ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

   always_comb begin
      if (!sub && (a[MSB] != b[MSB]))
         assert_mixed_add_no_overflow_R4: assert (!ovf)
            else $error("add of opposite signs flagged overflow");
      if (sub && (a == b))
         assert_self_subtract_zero_R3: assert (sum == '0 && !ovf)
            else $error("a-a not zero");
   end

endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
module alu_logic
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic_op_e        op,
   output logic [WIDTH-1:0] y
);

   always_comb begin
      unique case (op)
         LG_AND:  y = a & b;
         LG_OR:   y = a | b;
         LG_NOR:  y = ~(a | b);
         default: y = a ^ b;
      endcase
   end

   always_comb begin
      if (op == LG_NOR)
         assert_nor_disjoint_R7: assert ((y & (a | b)) == '0)
            else $error("NOR output overlaps operand bits");
      if (op == LG_AND)
         assert_and_subset_R7: assert ((y & ~a) == '0)
            else $error("AND output outside first operand");
   end

endmodule

// File: rtl/mfalu.sv
`timescale 1ns/1ps
module mfalu
   import alu_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter int EXTEND_STYLE = 1,
   localparam int SHW         = $clog2(WIDTH),
   localparam int MSB         = WIDTH - 1
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [SHW-1:0]   shamt,
   input  logic [1:0]       unit_sel,
   input  logic             sub_en,
   input  logic [1:0]       logic_op,
   input  logic [1:0]       shift_op,
   output logic [WIDTH-1:0] result,
   output logic             zero_flag,
   output logic             sign_flag,
   output logic             ovf_flag
);

   if (WIDTH < 4 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("mfalu: WIDTH must be a power of two of at least 4");
   end

   unit_sel_e        sel;
   logic             do_sub;
   logic [WIDTH-1:0] sh_y;
   logic [WIDTH-1:0] sum_y;
   logic [WIDTH-1:0] lg_y;
   logic             add_ovf;
   logic             lt_bit;

   assign sel    = unit_sel_e'(unit_sel);
   assign do_sub = sub_en || (sel == SEL_SLT);

   alu_shifter #(.WIDTH(WIDTH), .EXTEND_STYLE(EXTEND_STYLE)) u_shift (
      .din  (opa),
      .amt  (shamt),
      .op   (shift_op_e'(shift_op)),
      .dout (sh_y)
   );

   alu_addsub #(.WIDTH(WIDTH)) u_add (
      .a   (opa),
      .b   (opb),
      .sub (do_sub),
      .sum (sum_y),
      .ovf (add_ovf)
   );

   alu_logic #(.WIDTH(WIDTH)) u_logic (
      .a  (opa),
      .b  (opb),
      .op (logic_op_e'(logic_op)),
      .y  (lg_y)
   );

   assign lt_bit = sum_y[MSB] ^ add_ovf;

   always_comb begin
      unique case (sel)
         SEL_SHIFT: result = sh_y;
         SEL_SLT:   result = {{(WIDTH-1){1'b0}}, lt_bit};
         SEL_ARITH: result = sum_y;
         default:   result = lg_y;
      endcase
   end

   assign zero_flag = (result == '0);
   assign sign_flag = sum_y[MSB];
   assign ovf_flag  = add_ovf;

   always_comb begin
      if (sel == SEL_SLT)
         assert_slt_upper_clear_R6: assert (result[WIDTH-1:1] == '0)
            else $error("compare result has upper bits set");
      if (ovf_flag)
         assert_overflow_sign_flip_R4: assert (sign_flag != opa[MSB])
            else $error("overflow without sign flip");
   end

endmodule

// File: tb/mfalu_bench.sv
`timescale 1ns/1ps
module mfalu_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] opa, opb;
   logic [4:0]  shamt;
   logic [1:0]  unit_sel, logic_op, shift_op;
   logic        sub_en;
   logic [31:0] result;
   logic        zero_flag, sign_flag, ovf_flag;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   mfalu u_mfalu (
      .opa(opa), .opb(opb), .shamt(shamt), .unit_sel(unit_sel),
      .sub_en(sub_en), .logic_op(logic_op), .shift_op(shift_op),
      .result(result), .zero_flag(zero_flag), .sign_flag(sign_flag),
      .ovf_flag(ovf_flag)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [4:0] s,
                        input logic [1:0] sel, input logic sub, input logic [1:0] lop,
                        input logic [1:0] sop, output logic [31:0] r, output logic z,
                        output logic sg, output logic ov);
      longint sa, sb, sr;
      logic [31:0] sum;
      sa  = longint'($signed(a));
      sb  = longint'($signed(b));
      sr  = (sub || sel == 2'b01) ? sa - sb : sa + sb;
      sum = sr[31:0];
      ov  = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      sg  = sum[31];
      case (sel)
         2'b00: case (sop)
            2'b00: r = a << s;
            2'b01: r = $signed(a) >>> s;
            2'b10: r = a >> s;
            default: r = (s == 0) ? a : ((a >> s) | (a << (32 - int'(s))));
         endcase
         2'b01: r = (sa < sb) ? 32'd1 : 32'd0;
         2'b10: r = sum;
         default: case (lop)
            2'b00: r = a & b;
            2'b01: r = a | b;
            2'b10: r = ~(a | b);
            default: r = a ^ b;
         endcase
      endcase
      z = (r == 32'd0);
   endtask

   task automatic run(input string req, input logic [31:0] a, input logic [31:0] b,
                      input logic [4:0] s, input logic [1:0] sel, input logic sub,
                      input logic [1:0] lop, input logic [1:0] sop);
      logic [31:0] er;
      logic ez, es, eo;
      @(posedge clk);
      opa = a; opb = b; shamt = s; unit_sel = sel; sub_en = sub;
      logic_op = lop; shift_op = sop;
      model(a, b, s, sel, sub, lop, sop, er, ez, es, eo);
      @(negedge clk);
      check(req, result, er);
      check({req, " R11 zero"}, 32'(zero_flag), 32'(ez));
      check({req, " R5 sign"}, 32'(sign_flag), 32'(es));
      check({req, " R4 overflow"}, 32'(ovf_flag), 32'(eo));
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      opa = '0; opb = '0; shamt = '0; unit_sel = '0; sub_en = 1'b0;
      logic_op = '0; shift_op = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 reset-state result", result, 32'd0);
      check("R11 reset-state zero", 32'(zero_flag), 32'd1);

      // R2 / R3 arithmetic
      run("R2 add", 32'd7, 32'd9, 5'd0, 2'b10, 1'b0, 2'b00, 2'b00);
      run("R2 add wrap", 32'hFFFF_FFFF, 32'd1, 5'd0, 2'b10, 1'b0, 2'b00, 2'b00);
      run("R3 sub", 32'd5, 32'd9, 5'd0, 2'b10, 1'b1, 2'b00, 2'b00);
      run("R3 sub self", 32'h1234_5678, 32'h1234_5678, 5'd0, 2'b10, 1'b1, 2'b00, 2'b00);
      // R4 overflow boundaries
      run("R4 add pos ovf", 32'h7FFF_FFFF, 32'd1, 5'd0, 2'b10, 1'b0, 2'b00, 2'b00);
      run("R4 add neg ovf", 32'h8000_0000, 32'hFFFF_FFFF, 5'd0, 2'b10, 1'b0, 2'b00, 2'b00);
      run("R4 sub ovf", 32'h8000_0000, 32'd1, 5'd0, 2'b10, 1'b1, 2'b00, 2'b00);
      run("R4 sub no ovf", 32'hFFFF_FFFF, 32'h8000_0000, 5'd0, 2'b10, 1'b1, 2'b00, 2'b00);
      // R5 sign while another unit selected
      run("R5 sign under logic", 32'd1, 32'd3, 5'd0, 2'b11, 1'b1, 2'b00, 2'b00);
      // R6 signed compare
      run("R6 lt", 32'hFFFF_FFFE, 32'd3, 5'd0, 2'b01, 1'b0, 2'b00, 2'b00);
      run("R6 ge", 32'd3, 32'hFFFF_FFFE, 5'd0, 2'b01, 1'b0, 2'b00, 2'b00);
      run("R6 ovf lt", 32'h8000_0000, 32'd1, 5'd0, 2'b01, 1'b0, 2'b00, 2'b00);
      run("R6 ovf ge", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, 2'b01, 1'b0, 2'b00, 2'b00);
      run("R6 equal", 32'd42, 32'd42, 5'd0, 2'b01, 1'b0, 2'b00, 2'b00);
      // R7 logic
      for (int k = 0; k < 4; k++)
         run("R7 logic", 32'hF0F0_3C3C, 32'hFF00_0FF0, 5'd0, 2'b11, 1'b0, 2'(k), 2'b00);
      run("R7 nor zero", 32'hFFFF_FFFF, 32'd0, 5'd0, 2'b11, 1'b0, 2'b10, 2'b00);
      // R8 / R9 / R10 shifts
      run("R8 sll 0", 32'h8000_0001, 32'd0, 5'd0, 2'b00, 1'b0, 2'b00, 2'b00);
      run("R8 sll 31", 32'h8000_0003, 32'd0, 5'd31, 2'b00, 1'b0, 2'b00, 2'b00);
      run("R8 sll 4", 32'hABCD_1234, 32'd0, 5'd4, 2'b00, 1'b0, 2'b00, 2'b00);
      run("R9 srl", 32'h8000_00F0, 32'd0, 5'd4, 2'b00, 1'b0, 2'b00, 2'b10);
      run("R9 sra neg", 32'h8000_00F0, 32'd0, 5'd4, 2'b00, 1'b0, 2'b00, 2'b01);
      run("R9 sra 31", 32'h8000_0000, 32'd0, 5'd31, 2'b00, 1'b0, 2'b00, 2'b01);
      run("R9 sra pos", 32'h4000_0000, 32'd0, 5'd30, 2'b00, 1'b0, 2'b00, 2'b01);
      run("R10 ror 8", 32'h1234_5678, 32'd0, 5'd8, 2'b00, 1'b0, 2'b00, 2'b11);
      run("R10 ror 0", 32'h1234_5678, 32'd0, 5'd0, 2'b00, 1'b0, 2'b00, 2'b11);
      run("R10 ror 31", 32'h8000_0001, 32'd0, 5'd31, 2'b00, 1'b0, 2'b00, 2'b11);
      // R12 shift count independent of opb
      run("R12 opb a", 32'hDEAD_BEEF, 32'h0000_0000, 5'd3, 2'b00, 1'b0, 2'b00, 2'b10);
      run("R12 opb b", 32'hDEAD_BEEF, 32'hFFFF_FFFF, 5'd3, 2'b00, 1'b0, 2'b00, 2'b10);
      run("R12 opb c", 32'hDEAD_BEEF, 32'h0000_001F, 5'd3, 2'b00, 1'b0, 2'b00, 2'b10);
      // R1 mixed random traffic across all units
      for (int n = 0; n < 600; n++) begin
         logic [31:0] ra, rb;
         ra = $urandom();
         rb = (n % 7 == 0) ? ra : $urandom();
         run("R1 random", ra, rb, 5'($urandom()), 2'($urandom()), 1'($urandom()),
             2'($urandom()), 2'($urandom()));
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule